// File: doc/BRIEF.md
# Serial EEPROM Hub Configuration Loader

This block runs once after reset. It fetches a small configuration image from an external 128-byte three-wire serial EEPROM that is organised as 64 words of 16 bits. The block acts as bus master. It drives chip select, a divided serial clock and a command line, and it samples the memory's data line. The image holds a vendor ID, a product ID, a checksum, the number of downstream ports, a mask of ports with non-removable devices, and a max-power value in units of 2 mA.

When the loader has read the image, it judges the image as a whole. The image is accepted only when the memory answered, the checksum matches, the port count lies between 1 and MAX_PORTS, and the max-power value is legal. If any of these fails, every field is replaced by the built-in default parameters. The chosen values are held on registered outputs, together with a done flag, an accepted flag and a presence flag. A separate output tells the LED logic whether it may use the amber pins that the EEPROM interface shares.

The controller has seven states:
- IDLE: the state during reset; it always moves to CMD on the next clock.
- CMD: nine command bits are sent; then the controller moves to TURN.
- TURN: one dummy bit is sampled. The controller moves to DATA if the bit was 0, or to CHECK if it was 1 (memory absent).
- DATA: sixteen data bits are received; then the controller moves to GAP.
- GAP: one bit time with chip select low. The controller moves back to CMD for the next word, or to CHECK after the last word.
- CHECK: the image is judged and the results are registered; then the controller moves to DONE.
- DONE: terminal until the next reset.

Top module: `mw_cfg_loader`

## Requirements
- R1: During reset and until `cfg_done` rises, `ee_cs`, `ee_sk`, `cfg_done`, `cfg_valid`, `ee_present` and `amber_en` are 0, and the configuration outputs show the default parameters.
- R2: The loader reads words 0, 1, 2, 3 and 4 in that order, one read per chip-select assertion.
  - Each read sends the 3-bit pattern 1,1,0 (start bit, then read opcode) and then the 6-bit word address, MSB first on `ee_mosi`.
  - `ee_mosi` changes only while `ee_sk` is low.
  - Chip select stays low for one bit time between words.
- R3: `ee_sk` is low whenever `ee_cs` is low. Each high phase of `ee_sk` lasts CLK_HALF system clocks, and each bit time lasts 2*CLK_HALF clocks.
- R4: After the command, one dummy bit is sampled. If it reads 1, the EEPROM is taken as absent. The transfer stops, and the result is: `ee_present`=0, `cfg_valid`=0, default outputs.
- R5: The loader samples data on the rising `ee_sk` edge, 16 bits per word, MSB first. Bits [7:0] of word n hold byte 2n, and bits [15:8] hold byte 2n+1.
- R6: The image is rejected unless byte 4 equals the 8-bit wrapped sum of bytes 0, 1, 2, 3 and 1.
- R7: The image is rejected unless byte 6 lies in 1..MAX_PORTS.
- R8: The image is rejected if byte 8 is above 0xFA.
- R9: For an accepted image:
  - `cfg_valid`=1.
  - `cfg_vid` = {byte1, byte0} and `cfg_pid` = {byte3, byte2}.
  - `cfg_ports` = the low bits of byte 6.
  - `cfg_nonrem` = byte 7 [MAX_PORTS-1:0], where bit 0 is port 1 and a 1 marks the device as non-removable.
  - `cfg_maxpwr` = byte 8.
  - A rejected image gives the default on every field.
- R10: `cfg_done` rises exactly 270*CLK_HALF+2 clocks after reset is released when the memory answers, or 20*CLK_HALF+2 clocks when it does not. It then stays high, and all outputs stay stable until the next reset.
- R11: `amber_en` is high only once loading is done and no EEPROM was detected.
- R12: `ee_present` is 1 after loading whenever the dummy bit read 0, even if the image is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_mosi | output | 1 | Command and address bits to the EEPROM |
| ee_miso | input | 1 | Data from the EEPROM, pulled high when absent |
| cfg_vid | output | 16 | Selected vendor ID |
| cfg_pid | output | 16 | Selected product ID |
| cfg_ports | output | PORT_W | Selected downstream port count |
| cfg_nonrem | output | MAX_PORTS | Non-removable mask, bit 0 = port 1 |
| cfg_maxpwr | output | 8 | Selected max power, 2 mA units |
| cfg_done | output | 1 | Loading finished |
| cfg_valid | output | 1 | EEPROM image accepted |
| ee_present | output | 1 | EEPROM answered the read |
| amber_en | output | 1 | Amber LED pins may be driven |

## Verification
On every cycle, the assertions check several relations:
- the serial clock is quiet while deselected;
- the done flag, once set, holds, and the outputs it guards stay frozen;
- an accepted image always carries a legal port count and max-power value;
- a rejected or absent image shows the defaults;
- presence and amber enable exclude each other.

Other behaviour depends on the data stream and the exact load time, and only the bench scenarios can show it. This covers:
- the command bit pattern and the word address order;
- the byte placement inside each word;
- the checksum wrap-around;
- the boundary port counts and max-power values that flip the accept decision;
- the exact cycle at which done rises.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_TURN,
        ST_DATA,
        ST_GAP,
        ST_CHECK,
        ST_DONE
    } ld_state_t;

    // start bit followed by the two-bit read opcode
    localparam logic [2:0] MW_READ_HDR = 3'b110;

    // byte offsets inside the configuration image
    localparam int OFS_VID_LO  = 0;
    localparam int OFS_VID_HI  = 1;
    localparam int OFS_PID_LO  = 2;
    localparam int OFS_PID_HI  = 3;
    localparam int OFS_CSUM    = 4;
    localparam int OFS_SPARE   = 5;
    localparam int OFS_PORTS   = 6;
    localparam int OFS_NONREM  = 7;
    localparam int OFS_MAXPWR  = 8;
    localparam int LAST_CFG_BYTE = OFS_MAXPWR;

    localparam logic [7:0] MAXPWR_LIMIT = 8'hFA;

endpackage

// File: rtl/mw_bit_timer.sv
module mw_bit_timer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sk_level,
    output logic sample_pt,
    output logic slot_end
);
    localparam int SLOT = 2 * HALF;
    localparam int PH_W = (SLOT > 1) ? $clog2(SLOT) : 1;
    localparam logic [PH_W-1:0] PH_LAST   = PH_W'(SLOT - 1);
    localparam logic [PH_W-1:0] PH_SAMPLE = PH_W'(HALF - 1);
    localparam logic [PH_W-1:0] PH_HIGH   = PH_W'(HALF);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!run || phase == PH_LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign sk_level  = run && (phase >= PH_HIGH);
    assign sample_pt = run && (phase == PH_SAMPLE);
    assign slot_end  = run && (phase == PH_LAST);

endmodule

// File: rtl/cfg_image.sv
module cfg_image #(
    parameter int NUM_WORDS = 5,
    parameter int DATA_W    = 16,
    localparam int IDX_W    = $clog2(NUM_WORDS + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NUM_WORDS*DATA_W-1:0]   image
);
    genvar g;
    generate
        for (g = 0; g < NUM_WORDS; g++) begin : g_word
            logic [DATA_W-1:0] word_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (wr_en && wr_idx == IDX_W'(g)) begin
                    word_q <= wr_data;
                end
            end
            assign image[g*DATA_W +: DATA_W] = word_q;
        end
    endgenerate

endmodule

// File: rtl/cfg_check.sv
module cfg_check
    import cfgld_pkg::*;
#(
    parameter int          IMG_W      = 80,
    parameter int          MAX_PORTS  = 4,
    parameter logic [15:0] DEF_VID    = 16'h5A17,
    parameter logic [15:0] DEF_PID    = 16'h0310,
    parameter logic [7:0]  DEF_PORTS  = 8'd4,
    parameter logic [7:0]  DEF_NONREM = 8'h00,
    parameter logic [7:0]  DEF_MAXPWR = 8'h32,
    localparam int         PORT_W     = $clog2(MAX_PORTS + 1)
) (
    input  logic [IMG_W-1:0]     image,
    input  logic                 present,
    output logic                 accept,
    output logic [15:0]          sel_vid,
    output logic [15:0]          sel_pid,
    output logic [PORT_W-1:0]    sel_ports,
    output logic [MAX_PORTS-1:0] sel_nonrem,
    output logic [7:0]           sel_maxpwr
);
    logic [7:0] vid_lo, vid_hi, pid_lo, pid_hi, csum, ports_b, nonrem_b, maxpwr_b;
    logic [7:0] sum_calc;
    logic       csum_ok, ports_ok, pwr_ok;
    logic       unused_bits;

    assign vid_lo   = image[OFS_VID_LO*8 +: 8];
    assign vid_hi   = image[OFS_VID_HI*8 +: 8];
    assign pid_lo   = image[OFS_PID_LO*8 +: 8];
    assign pid_hi   = image[OFS_PID_HI*8 +: 8];
    assign csum     = image[OFS_CSUM*8 +: 8];
    assign ports_b  = image[OFS_PORTS*8 +: 8];
    assign nonrem_b = image[OFS_NONREM*8 +: 8];
    assign maxpwr_b = image[OFS_MAXPWR*8 +: 8];
    assign unused_bits = ^{image[OFS_SPARE*8 +: 8], image[IMG_W-1:(LAST_CFG_BYTE+1)*8],
                           ports_b[7:PORT_W], nonrem_b[7:MAX_PORTS]};

    always_comb begin
        sum_calc = vid_lo + vid_hi + pid_lo + pid_hi + 8'd1;
        csum_ok  = (csum == sum_calc);
        ports_ok = (ports_b != 8'd0) && (ports_b <= 8'(MAX_PORTS));
        pwr_ok   = (maxpwr_b <= MAXPWR_LIMIT);
        accept   = present && csum_ok && ports_ok && pwr_ok;
        if (accept) begin
            sel_vid    = {vid_hi, vid_lo};
            sel_pid    = {pid_hi, pid_lo};
            sel_ports  = ports_b[PORT_W-1:0];
            sel_nonrem = nonrem_b[MAX_PORTS-1:0];
            sel_maxpwr = maxpwr_b;
        end else begin
            sel_vid    = DEF_VID;
            sel_pid    = DEF_PID;
            sel_ports  = DEF_PORTS[PORT_W-1:0];
            sel_nonrem = DEF_NONREM[MAX_PORTS-1:0];
            sel_maxpwr = DEF_MAXPWR;
        end
    end

endmodule

// File: rtl/mw_cfg_loader.sv
module mw_cfg_loader
    import cfgld_pkg::*;
#(
    parameter int          CLK_HALF   = 2,
    parameter int          ADDR_W     = 6,
    parameter int          DATA_W     = 16,
    parameter int          MAX_PORTS  = 4,
    parameter logic [15:0] DEF_VID    = 16'h5A17,
    parameter logic [15:0] DEF_PID    = 16'h0310,
    parameter logic [7:0]  DEF_PORTS  = 8'd4,
    parameter logic [7:0]  DEF_NONREM = 8'h00,
    parameter logic [7:0]  DEF_MAXPWR = 8'h32,
    localparam int         PORT_W     = $clog2(MAX_PORTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 ee_cs,
    output logic                 ee_sk,
    output logic                 ee_mosi,
    input  logic                 ee_miso,
    output logic [15:0]          cfg_vid,
    output logic [15:0]          cfg_pid,
    output logic [PORT_W-1:0]    cfg_ports,
    output logic [MAX_PORTS-1:0] cfg_nonrem,
    output logic [7:0]           cfg_maxpwr,
    output logic                 cfg_done,
    output logic                 cfg_valid,
    output logic                 ee_present,
    output logic                 amber_en
);
    localparam int CMD_BITS   = 3 + ADDR_W;
    localparam int BYTES_WORD = DATA_W / 8;
    localparam int NUM_WORDS  = LAST_CFG_BYTE / BYTES_WORD + 1;
    localparam int IDX_W      = $clog2(NUM_WORDS + 1);
    localparam int CNT_MAX    = (CMD_BITS > DATA_W) ? CMD_BITS : DATA_W;
    localparam int CNT_W      = $clog2(CNT_MAX);
    localparam int IMG_W      = NUM_WORDS * DATA_W;

    ld_state_t            state, state_nx;
    logic [CNT_W-1:0]     bit_cnt;
    logic [IDX_W-1:0]     word_idx;
    logic [CMD_BITS-1:0]  cmd_sh;
    logic [DATA_W-1:0]    rx_sh;
    logic                 turn_high;
    logic                 sk_level, sample_pt, slot_end, timer_run;
    logic                 cmd_last, data_last, img_wr;
    logic [IMG_W-1:0]     image;
    logic                 accept;
    logic [15:0]          sel_vid, sel_pid;
    logic [PORT_W-1:0]    sel_ports;
    logic [MAX_PORTS-1:0] sel_nonrem;
    logic [7:0]           sel_maxpwr;

    assign cmd_last  = (bit_cnt == CNT_W'(CMD_BITS - 1));
    assign data_last = (bit_cnt == CNT_W'(DATA_W - 1));
    assign timer_run = (state == ST_CMD) || (state == ST_TURN) ||
                       (state == ST_DATA) || (state == ST_GAP);
    assign img_wr    = (state == ST_DATA) && slot_end && data_last;

    mw_bit_timer #(.HALF(CLK_HALF)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (timer_run),
        .sk_level  (sk_level),
        .sample_pt (sample_pt),
        .slot_end  (slot_end)
    );

    cfg_image #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)) u_image (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (img_wr),
        .wr_idx  (word_idx),
        .wr_data (rx_sh),
        .image   (image)
    );

    cfg_check #(
        .IMG_W(IMG_W), .MAX_PORTS(MAX_PORTS), .DEF_VID(DEF_VID), .DEF_PID(DEF_PID),
        .DEF_PORTS(DEF_PORTS), .DEF_NONREM(DEF_NONREM), .DEF_MAXPWR(DEF_MAXPWR)
    ) u_check (
        .image      (image),
        .present    (!turn_high),
        .accept     (accept),
        .sel_vid    (sel_vid),
        .sel_pid    (sel_pid),
        .sel_ports  (sel_ports),
        .sel_nonrem (sel_nonrem),
        .sel_maxpwr (sel_maxpwr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = ST_CMD;
            ST_CMD:   if (slot_end && cmd_last)  state_nx = ST_TURN;
            ST_TURN:  if (slot_end)              state_nx = turn_high ? ST_CHECK : ST_DATA;
            ST_DATA:  if (slot_end && data_last) state_nx = ST_GAP;
            ST_GAP:   if (slot_end)              state_nx = (word_idx == IDX_W'(NUM_WORDS)) ? ST_CHECK : ST_CMD;
            ST_CHECK: state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_DONE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // bit-level datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            word_idx  <= '0;
            cmd_sh    <= '0;
            rx_sh     <= '0;
            turn_high <= 1'b0;
        end else begin
            if (state_nx != state)  bit_cnt <= '0;
            else if (slot_end)      bit_cnt <= bit_cnt + 1'b1;

            if (state == ST_IDLE)   word_idx <= '0;
            else if (img_wr)        word_idx <= word_idx + 1'b1;

            if (state == ST_IDLE || state == ST_GAP)
                cmd_sh <= {MW_READ_HDR, ADDR_W'(word_idx)};
            else if (state == ST_CMD && slot_end)
                cmd_sh <= cmd_sh << 1;

            if (state == ST_DATA && sample_pt)
                rx_sh <= {rx_sh[DATA_W-2:0], ee_miso};

            if (state == ST_IDLE)                      turn_high <= 1'b0;
            else if (state == ST_TURN && sample_pt)    turn_high <= ee_miso;
        end
    end

    // pin outputs
    always_comb begin
        ee_cs   = (state == ST_CMD) || (state == ST_TURN) || (state == ST_DATA);
        ee_sk   = ee_cs && sk_level;
        ee_mosi = (state == ST_CMD) && cmd_sh[CMD_BITS-1];
    end

    // result outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_vid    <= DEF_VID;
            cfg_pid    <= DEF_PID;
            cfg_ports  <= DEF_PORTS[PORT_W-1:0];
            cfg_nonrem <= DEF_NONREM[MAX_PORTS-1:0];
            cfg_maxpwr <= DEF_MAXPWR;
            cfg_done   <= 1'b0;
            cfg_valid  <= 1'b0;
            ee_present <= 1'b0;
            amber_en   <= 1'b0;
        end else if (state == ST_CHECK) begin
            cfg_vid    <= sel_vid;
            cfg_pid    <= sel_pid;
            cfg_ports  <= sel_ports;
            cfg_nonrem <= sel_nonrem;
            cfg_maxpwr <= sel_maxpwr;
            cfg_done   <= 1'b1;
            cfg_valid  <= accept;
            ee_present <= !turn_high;
            amber_en   <= turn_high;
        end
    end

endmodule

// File: rtl/cfgld_props.sv
module cfgld_props #(
    parameter int          MAX_PORTS = 4,
    parameter logic [15:0] DEF_VID   = 16'h5A17,
    parameter logic [15:0] DEF_PID   = 16'h0310,
    localparam int         PORT_W    = $clog2(MAX_PORTS + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ee_cs,
    input logic                 ee_sk,
    input logic [15:0]          cfg_vid,
    input logic [15:0]          cfg_pid,
    input logic [PORT_W-1:0]    cfg_ports,
    input logic [MAX_PORTS-1:0] cfg_nonrem,
    input logic [7:0]           cfg_maxpwr,
    input logic                 cfg_done,
    input logic                 cfg_valid,
    input logic                 ee_present,
    input logic                 amber_en
);
    assert_sk_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sk);

    assert_cs_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> !ee_cs);

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done);

    assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> ($stable(cfg_vid) && $stable(cfg_pid) && $stable(cfg_ports) &&
                      $stable(cfg_nonrem) && $stable(cfg_maxpwr) && $stable(cfg_valid) &&
                      $stable(ee_present)));

    assert_idle_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> (!cfg_valid && !ee_present && !amber_en));

    assert_ports_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (cfg_ports != '0 && cfg_ports <= PORT_W'(MAX_PORTS)));

    assert_power_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (cfg_maxpwr <= 8'hFA));

    assert_defaults_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && !cfg_valid) |-> (cfg_vid == DEF_VID && cfg_pid == DEF_PID));

    assert_valid_present_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> ee_present);

    assert_amber_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ee_present |-> !amber_en);

endmodule

bind mw_cfg_loader cfgld_props #(
    .MAX_PORTS(MAX_PORTS), .DEF_VID(DEF_VID), .DEF_PID(DEF_PID)
) u_props (
    .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .cfg_vid(cfg_vid), .cfg_pid(cfg_pid), .cfg_ports(cfg_ports),
    .cfg_nonrem(cfg_nonrem), .cfg_maxpwr(cfg_maxpwr), .cfg_done(cfg_done),
    .cfg_valid(cfg_valid), .ee_present(ee_present), .amber_en(amber_en)
);

// File: tb/sim_mw_cfg_loader.sv
module sim_mw_cfg_loader;
    localparam int          CH      = 2;
    localparam logic [15:0] D_VID   = 16'h5A17;
    localparam logic [15:0] D_PID   = 16'h0310;
    localparam logic [7:0]  D_PORTS = 8'd4;
    localparam logic [7:0]  D_NREM  = 8'h00;
    localparam logic [7:0]  D_PWR   = 8'h32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ee_miso = 1'b1;
    logic ee_cs, ee_sk, ee_mosi;
    logic [15:0] cfg_vid, cfg_pid;
    logic [2:0]  cfg_ports;
    logic [3:0]  cfg_nonrem;
    logic [7:0]  cfg_maxpwr;
    logic cfg_done, cfg_valid, ee_present, amber_en;

    int  vectors = 0;
    int  miscompares = 0;
    bit  finished = 0;
    bit  rom_on = 0;
    int  exp_word = 0;
    logic [7:0] rom [128];

    always #10 clk = ~clk;

    mw_cfg_loader #(
        .CLK_HALF(CH), .DEF_VID(D_VID), .DEF_PID(D_PID), .DEF_PORTS(D_PORTS),
        .DEF_NONREM(D_NREM), .DEF_MAXPWR(D_PWR)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_mosi(ee_mosi),
        .ee_miso(ee_miso), .cfg_vid(cfg_vid), .cfg_pid(cfg_pid), .cfg_ports(cfg_ports),
        .cfg_nonrem(cfg_nonrem), .cfg_maxpwr(cfg_maxpwr), .cfg_done(cfg_done),
        .cfg_valid(cfg_valid), .ee_present(ee_present), .amber_en(amber_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural EEPROM: commands clocked in on rising SK, data out on falling SK
    initial begin
        forever begin
            logic [8:0]  cmd;
            logic [15:0] word;
            @(posedge ee_cs);
            if (!rom_on) continue;
            cmd = '0;
            for (int i = 0; i < 9; i++) begin
                @(posedge ee_sk);
                cmd = {cmd[7:0], ee_mosi};
            end
            chk(cmd[8:6] == 3'b110, "R2", "read header", 64'(cmd[8:6]), 64'h6);
            chk(int'(cmd[5:0]) == exp_word, "R2", "word address", 64'(cmd[5:0]), 64'(exp_word));
            word = {rom[2*cmd[5:0]+1], rom[2*cmd[5:0]]};
            @(negedge ee_sk);
            ee_miso = 1'b0;
            for (int b = 15; b >= 0; b--) begin
                @(negedge ee_sk);
                ee_miso = word[b];
            end
            @(negedge ee_cs);
            ee_miso = 1'b1;
            exp_word++;
        end
    end

    function automatic logic [50:0] pack_out();
        return {cfg_done, cfg_valid, ee_present, amber_en, cfg_vid, cfg_pid,
                cfg_ports, cfg_nonrem, cfg_maxpwr};
    endfunction

    task automatic run_case(input bit present_i, input string req);
        logic [7:0]  sum;
        bit          ok;
        int          t_done;
        int          hi_run;
        logic [50:0] exp_idle, exp_fin, exp_now, act;
        rom_on  = present_i;
        ee_miso = 1'b1;
        exp_word = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({ee_cs, ee_sk} == 2'b00, "R1", "pins in reset", 64'({ee_cs, ee_sk}), 64'h0);
        sum = rom[0] + rom[1] + rom[2] + rom[3] + 8'd1;
        ok  = present_i && (rom[4] == sum) && (rom[6] >= 8'd1) && (rom[6] <= 8'd4) &&
              (rom[8] <= 8'hFA);
        exp_idle = {4'b0000, D_VID, D_PID, D_PORTS[2:0], D_NREM[3:0], D_PWR};
        if (ok)
            exp_fin = {1'b1, 1'b1, 1'b1, 1'b0, rom[1], rom[0], rom[3], rom[2],
                       rom[6][2:0], rom[7][3:0], rom[8]};
        else
            exp_fin = {1'b1, 1'b0, present_i, !present_i, D_VID, D_PID, D_PORTS[2:0],
                       D_NREM[3:0], D_PWR};
        act = pack_out();
        chk(act == exp_idle, "R1", "outputs in reset", 64'(act), 64'(exp_idle));
        t_done = present_i ? 270 * CH + 2 : 20 * CH + 2;
        hi_run = 0;
        rst_n = 1'b1;
        for (int n = 1; n <= t_done + 20; n++) begin
            @(negedge clk);
            exp_now = (n >= t_done) ? exp_fin : exp_idle;
            act = pack_out();
            if (n == t_done)
                chk(act == exp_now, "R10", "done edge", 64'(act), 64'(exp_now));
            else
                chk(act == exp_now, (n < t_done) ? "R1" : req, "outputs", 64'(act), 64'(exp_now));
            if (!ee_cs && ee_sk) chk(1'b0, "R3", "sk while deselected", 64'h1, 64'h0);
            if (ee_sk) hi_run++;
            else begin
                if (hi_run != 0) chk(hi_run == CH, "R3", "sk high width", 64'(hi_run), 64'(CH));
                hi_run = 0;
            end
        end
        if (present_i) chk(exp_word == 5, "R2", "words read", 64'(exp_word), 64'd5);
    endtask

    task automatic load_good();
        for (int i = 0; i < 128; i++) rom[i] = 8'(i * 37 + 11);
        rom[0] = 8'h34; rom[1] = 8'h12; rom[2] = 8'hCD; rom[3] = 8'hAB;
        rom[4] = 8'hBF;              // wraps past 8 bits
        rom[6] = 8'd3; rom[7] = 8'hA5; rom[8] = 8'h32;
    endtask

    initial begin
        // R4 R11: no memory, line stays high
        for (int i = 0; i < 128; i++) rom[i] = 8'h00;
        run_case(1'b0, "R4_R11");
        // R5 R9 R6: accepted image with checksum wrap
        load_good();
        run_case(1'b1, "R9_R5");
        // R6 R12: wrong checksum, memory still present
        load_good(); rom[4] = 8'hC0;
        run_case(1'b1, "R6_R12");
        // R7: port count zero and five
        load_good(); rom[6] = 8'd0;
        run_case(1'b1, "R7");
        load_good(); rom[6] = 8'd5;
        run_case(1'b1, "R7");
        // R8: max power one above limit, then at limit with one port
        load_good(); rom[8] = 8'hFB;
        run_case(1'b1, "R8");
        load_good(); rom[8] = 8'hFA; rom[6] = 8'd1; rom[7] = 8'h0F;
        run_case(1'b1, "R8_R9");
        // R7 R9: four ports accepted, different IDs
        load_good(); rom[0] = 8'hFF; rom[1] = 8'h00; rom[2] = 8'h01; rom[3] = 8'h80;
        rom[4] = 8'hFF + 8'h00 + 8'h01 + 8'h80 + 8'h01; rom[6] = 8'd4; rom[7] = 8'h06;
        run_case(1'b1, "R7_R9");
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog run did not complete");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule